// File: doc/BRIEF.md
# Burst-of-Two Separate-Port SRAM Core

This block is a synthesizable functional model of a double-rate static memory. It has an input port and an output port that work at the same time. Every access moves exactly two words. Commands and addresses are taken on both halves of a master period. The block runs from one clock at twice the master rate. An internal phase flag, `k_phase`, tells the two half-periods apart. An edge taken while `k_phase` is 0 is a master rising edge ("K edge"). The edge that follows it is the complementary rising edge ("K# edge").

Writes are posted. A write is first held in a one-entry buffer. It reaches the array only when the next write's address is taken. Reads see the newest data. They merge the buffered bytes over the array contents, one byte at a time.

There is no real tristate. The read port drives `rd_oe` as an output-enable, and it forces `rdata` to zero while the port is idle.

Top module: `qburst_sram`

## Requirements
- R1: After reset `k_phase` is 0, and it then toggles on every clock edge. Commands are decoded only on edges taken while `k_phase` is 0 (K edges).
- R2: When `rd_n` is low at a K edge, `addr` is the read address. After the K# edge of the next period (3 edges later), `rdata` carries word {addr,0} with `rd_oe` high. After the following K edge, `rdata` carries word {addr,1}.
- R3: When `wr_n` is low at a K edge, the first data beat and its byte enables are taken from `wdata` and `bwe_n` at that edge. The write address and the second beat with its enables are taken from `addr`, `wdata` and `bwe_n` at the following K# edge.
- R4: Byte enables are active low. Bit i of `bwe_n` guards data bits [9i+8:9i] of its beat, and each beat has its own enables. A beat whose enables are all high leaves every byte of that word unchanged.
- R5: A write is held in a buffer. It is committed to the array, with its own byte enables, at the K# edge that takes the address of the next write. Later reads then see it through the array.
- R6: A read returns every write whose command K edge is at or before the read's K edge. This includes a write issued in the same period. Enabled bytes of the buffered write replace the array bytes, one byte at a time, and a write in a later period does not affect the read.
- R7: Reads and writes run independently. Issuing both in the same period, to any addresses, changes neither one's timing or data.
- R8: A K edge with `rd_n` high does not shorten a read already in flight. Four edges after such a K edge, `rd_oe` is low. While `rd_oe` is low, `rdata` is zero.
- R9: After reset `rd_oe` is low, `rdata` is zero, the write buffer is empty and every array word reads as zero.
- R10: Reads issued at consecutive K edges give an unbroken output stream, with `rd_oe` held high and one word per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the master rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Read command, active low, sampled on K edges |
| wr_n | input | 1 | Write command, active low, sampled on K edges |
| addr | input | AW | Read address on K edges; write address on K# edges |
| wdata | input | 36 | First write beat on K edges; second beat on K# edges |
| bwe_n | input | 4 | Active-low byte enables for the beat on `wdata` |
| k_phase | output | 1 | 0 when the next edge is a K edge |
| rdata | output | 36 | Read data, one word per edge |
| rd_oe | output | 1 | Output enable for `rdata` |

## Verification
The assertions assume the following about the inputs: `rd_n` and `wr_n` matter only when `k_phase` is 0, and a command's second half always follows on the very next edge. The bench changes inputs only at falling clock edges. It starts every command while `k_phase` is 0, and it parks both command pins high during the K# half. The latency and idle properties therefore see only well-formed command slots. Every read beat is compared against a reference memory. That memory applies the same rules: a write posted until the next write, and per-byte merging from the buffer. Collisions are forced by confining the random traffic to a few addresses.

// File: rtl/qburst_sram.sv
module qburst_sram #(
  parameter int AW     = 4,
  parameter int BYTE_W = 9,
  parameter int NBYTE  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_n,
  input  logic                    wr_n,
  input  logic [AW-1:0]           addr,
  input  logic [BYTE_W*NBYTE-1:0] wdata,
  input  logic [NBYTE-1:0]        bwe_n,
  output logic                    k_phase,
  output logic [BYTE_W*NBYTE-1:0] rdata,
  output logic                    rd_oe
);
  localparam int DW    = BYTE_W * NBYTE;
  localparam int WORDS = 2 ** (AW + 1);

  logic             ph;
  logic [DW-1:0]    mem [WORDS];

  logic             rp;
  logic [AW-1:0]    ra;
  logic             wp;
  logic [DW-1:0]    wd0;
  logic [NBYTE-1:0] wb0;

  logic             bv;
  logic [AW-1:0]    ba;
  logic [DW-1:0]    bd0, bd1;
  logic [NBYTE-1:0] bb0, bb1;

  logic             sv;
  logic [DW-1:0]    sq0, sq1;
  logic [DW-1:0]    fwd0, fwd1;
  logic             hit;

  assign k_phase = ph;
  assign hit     = bv && (ba == ra);

  for (genvar b = 0; b < NBYTE; b++) begin : g_fwd
    assign fwd0[b*BYTE_W +: BYTE_W] = (hit && !bb0[b]) ? bd0[b*BYTE_W +: BYTE_W]
                                                       : mem[{ra, 1'b0}][b*BYTE_W +: BYTE_W];
    assign fwd1[b*BYTE_W +: BYTE_W] = (hit && !bb1[b]) ? bd1[b*BYTE_W +: BYTE_W]
                                                       : mem[{ra, 1'b1}][b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= 1'b0;
      rp    <= 1'b0;
      ra    <= '0;
      wp    <= 1'b0;
      wd0   <= '0;
      wb0   <= '1;
      bv    <= 1'b0;
      ba    <= '0;
      bd0   <= '0;
      bd1   <= '0;
      bb0   <= '1;
      bb1   <= '1;
      sv    <= 1'b0;
      sq0   <= '0;
      sq1   <= '0;
      rdata <= '0;
      rd_oe <= 1'b0;
    end else begin
      ph <= ~ph;
      if (!ph) begin
        rp <= ~rd_n;
        if (!rd_n) ra <= addr;
        wp <= ~wr_n;
        if (!wr_n) begin
          wd0 <= wdata;
          wb0 <= bwe_n;
        end
        sv    <= rp;
        sq0   <= rp ? fwd0 : '0;
        sq1   <= rp ? fwd1 : '0;
        rd_oe <= sv;
        rdata <= sq1;
      end else begin
        rd_oe <= sv;
        rdata <= sq0;
        if (wp) begin
          bv  <= 1'b1;
          ba  <= addr;
          bd0 <= wd0;
          bb0 <= wb0;
          bd1 <= wdata;
          bb1 <= bwe_n;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (ph && wp && bv) begin
      for (int b = 0; b < NBYTE; b++) begin
        if (!bb0[b]) mem[{ba, 1'b0}][b*BYTE_W +: BYTE_W] <= bd0[b*BYTE_W +: BYTE_W];
        if (!bb1[b]) mem[{ba, 1'b1}][b*BYTE_W +: BYTE_W] <= bd1[b*BYTE_W +: BYTE_W];
      end
    end
  end

  a_r1_phase_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ph != $past(ph)));

  a_r1_oe_rises_on_kbar: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) |-> !ph);

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph && !rd_n) |-> ##4 rd_oe ##1 rd_oe);

  a_r8_nop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ph && rd_n) |-> ##4 !rd_oe);

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rdata == '0));

  a_r5_buffer_kept: assert property (@(posedge clk) disable iff (!rst_n)
    bv |=> bv);
endmodule

// File: tb/qburst_sram_test.sv
module qburst_sram_test;
  localparam int AW = 4, BYTE_W = 9, NBYTE = 4;
  localparam int DW = BYTE_W * NBYTE;
  localparam int WORDS = 2 ** (AW + 1);
  localparam int NCYC = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NBYTE-1:0] bwe_n = '1;
  logic k_phase, rd_oe;
  logic [DW-1:0] rdata;

  always #10 clk = ~clk;

  qburst_sram #(.AW(AW), .BYTE_W(BYTE_W), .NBYTE(NBYTE)) uut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .bwe_n(bwe_n), .k_phase(k_phase), .rdata(rdata), .rd_oe(rd_oe));

  int n_tests = 0, n_fail = 0, cyc = 0;
  string cur = "R9";
  logic [31:0] seed = 32'h1234_5678;

  logic [DW-1:0]    rmem [WORDS];
  bit               bv = 0;
  logic [AW-1:0]    ba;
  logic [DW-1:0]    bd [2];
  logic [NBYTE-1:0] bb [2];
  bit               ev [NCYC];
  logic [DW-1:0]    e0 [NCYC];
  logic [DW-1:0]    e1 [NCYC];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s (cycle %0d): actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [DW-1:0] pat(int a, int k, int s);
    logic [63:0] x;
    x = 64'(a * 7919 + k * 104729 + s * 15485863 + 1) * 64'h9E37_79B9_7F4A_7C15;
    return x[DW-1:0] ^ x[63:28];
  endfunction

  function automatic logic [DW-1:0] merged(logic [AW-1:0] a, int k);
    logic [DW-1:0] w;
    w = rmem[{a, k[0]}];
    if (bv && ba == a)
      for (int b = 0; b < NBYTE; b++)
        if (!bb[k][b]) w[b*BYTE_W +: BYTE_W] = bd[k][b*BYTE_W +: BYTE_W];
    return w;
  endfunction

  task automatic ref_write(logic [AW-1:0] a, logic [DW-1:0] d0, logic [NBYTE-1:0] m0,
                           logic [DW-1:0] d1, logic [NBYTE-1:0] m1);
    if (bv)
      for (int k = 0; k < 2; k++)
        for (int b = 0; b < NBYTE; b++)
          if (!bb[k][b]) rmem[{ba, k[0]}][b*BYTE_W +: BYTE_W] = bd[k][b*BYTE_W +: BYTE_W];
    bv = 1; ba = a;
    bd[0] = d0; bb[0] = m0; bd[1] = d1; bb[1] = m1;
  endtask

  task automatic check_beat(int k);
    bit v;
    logic [DW-1:0] d;
    v = (cyc >= 2) ? ev[cyc-2] : 1'b0;
    d = !v ? '0 : (k == 0 ? e0[cyc-2] : e1[cyc-2]);
    if (v) begin
      chk(cur, "rd_oe", 64'(rd_oe), 64'd1);
      chk(cur, k == 0 ? "rdata beat0" : "rdata beat1", 64'(rdata), 64'(d));
    end else begin
      chk("R8", "rd_oe idle", 64'(rd_oe), 64'd0);
      chk("R8", "rdata idle", 64'(rdata), 64'd0);
    end
  endtask

  task automatic kcyc(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                      logic [DW-1:0] d0, logic [NBYTE-1:0] m0,
                      logic [DW-1:0] d1, logic [NBYTE-1:0] m1);
    chk("R1", "k_phase at K slot", 64'(k_phase), 64'd0);
    check_beat(0);
    rd_n = !rd; wr_n = !wr; addr = ra; wdata = d0; bwe_n = m0;
    if (wr) ref_write(wa, d0, m0, d1, m1);
    ev[cyc] = rd;
    if (rd) begin
      e0[cyc] = merged(ra, 0);
      e1[cyc] = merged(ra, 1);
    end
    @(posedge clk); @(negedge clk);
    chk("R1", "k_phase at K# slot", 64'(k_phase), 64'd1);
    check_beat(1);
    rd_n = 1'b1; wr_n = 1'b1; addr = wa; wdata = d1; bwe_n = m1;
    @(posedge clk); @(negedge clk);
    cyc++;
  endtask

  task automatic rd_only(logic [AW-1:0] a);
    kcyc(1, a, 0, '0, '0, '1, '0, '1);
  endtask

  task automatic wr_only(logic [AW-1:0] a, logic [DW-1:0] d0, logic [NBYTE-1:0] m0,
                         logic [DW-1:0] d1, logic [NBYTE-1:0] m1);
    kcyc(0, '0, 1, a, d0, m0, d1, m1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) kcyc(0, '0, 0, '0, '0, '1, '0, '1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) rmem[i] = '0;
    for (int i = 0; i < NCYC; i++) ev[i] = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "rd_oe in reset", 64'(rd_oe), 64'd0);
    chk("R9", "rdata in reset", 64'(rdata), 64'd0);
    chk("R1", "k_phase in reset", 64'(k_phase), 64'd0);
    rst_n = 1'b1;

    cur = "R9";
    for (int a = 0; a < 2 ** AW; a++) rd_only(AW'(a));
    idle(2);

    cur = "R3";
    for (int a = 0; a < 2 ** AW; a++) wr_only(AW'(a), pat(a, 0, 1), '0, pat(a, 1, 1), '0);
    cur = "R2";
    for (int a = 0; a < 2 ** AW; a++) begin rd_only(AW'(a)); idle(1); end
    idle(2);
    cur = "R10";
    for (int a = 2 ** AW - 1; a >= 0; a--) rd_only(AW'(a));
    idle(2);

    cur = "R4";
    for (int m = 0; m < 2 ** NBYTE; m++)
      wr_only(AW'(m), pat(m, 0, 2), NBYTE'(m), pat(m, 1, 2), ~NBYTE'(m));
    for (int a = 0; a < 2 ** AW; a++) rd_only(AW'(a));
    idle(2);

    cur = "R5";
    wr_only(3, pat(3, 0, 3), '0, pat(3, 1, 3), '0);
    rd_only(3);
    wr_only(3, pat(3, 0, 4), 4'b1010, pat(3, 1, 4), 4'b0101);
    rd_only(3);
    wr_only(9, pat(9, 0, 4), 4'b0011, pat(9, 1, 4), 4'b1100);
    rd_only(3);
    rd_only(9);
    idle(2);

    cur = "R6";
    for (int a = 0; a < 4; a++) begin
      kcyc(1, AW'(a), 1, AW'(a), pat(a, 0, 5), NBYTE'(a * 5), pat(a, 1, 5), NBYTE'(a * 3));
      kcyc(1, AW'(a), 0, '0, '0, '1, '0, '1);
      kcyc(1, AW'(a), 1, AW'(a), pat(a, 0, 6), '0, pat(a, 1, 6), '0);
      rd_only(AW'(a));
    end
    idle(2);

    cur = "R7";
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = rnd();
      kcyc(r[0], AW'(r[3:2]), r[1], AW'(r[5:4]),
           pat(i, 0, 7), NBYTE'(r[11:8]), pat(i, 1, 7), NBYTE'(r[15:12]));
    end
    idle(2);

    cur = "R8";
    rd_only(1); idle(1); rd_only(2); idle(2); rd_only(3); rd_only(4); idle(1);
    rd_only(5); idle(3);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] r;
      r = rnd();
      if (r[0]) rd_only(AW'(r[7:4])); else idle(1);
    end
    idle(3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule